// File: doc/BRIEF.md
# Power Mode Controller

This block holds the operating mode of a chip and moves it between six modes: normal run, high-speed run, low-power run, two stop variants (stop1 and stop2) and low-power stop. Software changes the mode through a small register port. A deep-sleep request from the processor takes the chip into a stop mode, a wake interrupt brings it back, and a synchronous reset always returns it to normal run.

Every move is checked before it starts. Protection bits must allow the target mode, and some pairs of modes may not be joined directly. An illegal request leaves the mode as it was. A legal move is handed to an external entry/exit sequencer. The sequencer takes `seq_req` and `seq_target`, and the new mode takes effect only when it answers with `seq_done`. Low-power stop records the run mode it was entered from and returns to that mode on wake. The current mode is reported as a one-hot status code.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is normal run, the status reads 0x01, the guard, control and option registers read 0, and `seq_req` is low.
- R2: Register map by address: 0 is the guard (bit0 allows low-power modes, bit1 allows high-speed run), 1 is the control (bits[1:0] run field, bits[4:2] stop field), 2 is the stop option (bits[1:0]), and 3 is the read-only status. Unused bits read 0.
- R3: Status codes are one-hot: normal run 0x01, low-power run 0x04, high-speed run 0x80, stop1 0x10, stop2 0x20, low-power stop 0x40.
- R4: From normal run, writing run field 11 enters high-speed run only when guard bit1 is set, and writing run field 10 enters low-power run only when guard bit0 is set. Otherwise the mode is unchanged.
- R5: Writing run field 00 in high-speed run or in low-power run returns to normal run.
- R6: A run field write from high-speed run to low-power run, or the reverse, is rejected. A deep-sleep request in high-speed run is also rejected. The mode stays unchanged in all of these cases.
- R7: A deep-sleep request in normal run with stop field 000 enters stop1 when the option is 01 and stop2 when it is 10. With option 00 or 11 the request is rejected.
- R8: A deep-sleep request enters low-power stop when guard bit0 is set and either the mode is normal run with stop field 010, or the mode is low-power run with stop field 000 or 010.
- R9: A wake interrupt returns stop1 and stop2 to normal run. It returns low-power stop to the run mode that low-power stop was entered from.
- R10: A legal move raises `seq_req` the cycle after the request, with `seq_target` holding the target (0 normal run, 1 high-speed, 2 low-power run, 3 stop1, 4 stop2, 5 low-power stop). Both hold until `seq_done`. Mode and status change only at the edge where `seq_done` is sampled high, so the old status reads until then.
- R11: Register writes, deep-sleep requests and wake interrupts are ignored while a move is in progress.
- R12: Reset in any mode returns the chip to normal run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data (combinational) |
| sleep_req | input | 1 | Deep-sleep request from the processor |
| wake_irq | input | 1 | Wake interrupt |
| seq_req | output | 1 | Move request to the entry/exit sequencer |
| seq_target | output | 3 | Target mode code of the pending move |
| seq_done | input | 1 | Sequencer completion |
| status_o | output | 8 | One-hot current mode |

## Verification
The assertions assume the sequencer raises `seq_done` only while `seq_req` is high. They also assume reset is held for at least one full cycle. The bench's sequencer model respects both: it answers only a pending request, after a programmable latency, and for exactly one cycle. The bench applies reset for several cycles. Requests are applied one at a time, so the priority order among simultaneous requests is defined but is not what the checks rely on.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MD_RUN     = 3'd0,
        MD_HIGH    = 3'd1,
        MD_LOWRUN  = 3'd2,
        MD_HALT1   = 3'd3,
        MD_HALT2   = 3'd4,
        MD_LOWHALT = 3'd5
    } pmode_e;

    localparam int ADDR_GUARD = 0;
    localparam int ADDR_CTRL  = 1;
    localparam int ADDR_OPT   = 2;
    localparam int ADDR_STAT  = 3;

    localparam logic [1:0] RUN_NORM   = 2'b00;
    localparam logic [1:0] RUN_LOW    = 2'b10;
    localparam logic [1:0] RUN_HIGH   = 2'b11;
    localparam logic [2:0] STOP_PLAIN = 3'b000;
    localparam logic [2:0] STOP_LOW   = 3'b010;
    localparam logic [1:0] OPT_ONE    = 2'b01;
    localparam logic [1:0] OPT_TWO    = 2'b10;

    typedef struct packed {
        logic allow_hs;
        logic allow_vlp;
    } guard_t;

    typedef struct packed {
        logic [2:0] stop_sel;
        logic [1:0] run_sel;
    } ctrl_t;

    typedef struct packed {
        logic   go;
        pmode_e target;
    } plan_t;

    function automatic logic [7:0] status_code(pmode_e m);
        case (m)
            MD_RUN:     return 8'h01;
            MD_LOWRUN:  return 8'h04;
            MD_HALT1:   return 8'h10;
            MD_HALT2:   return 8'h20;
            MD_LOWHALT: return 8'h40;
            MD_HIGH:    return 8'h80;
            default:    return 8'h01;
        endcase
    endfunction

    function automatic logic is_run_mode(pmode_e m);
        return (m == MD_RUN) || (m == MD_HIGH) || (m == MD_LOWRUN);
    endfunction

endpackage

// File: rtl/pmc_regfile.sv
module pmc_regfile
    import pmc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          lock,
    input  logic [AW-1:0] rd_addr,
    input  logic [7:0]    status,
    output guard_t        guard,
    output ctrl_t         ctrl,
    output logic [1:0]    stop_opt,
    output logic [DW-1:0] rd_data
);
    localparam int GW = $bits(guard_t);
    localparam int CW = $bits(ctrl_t);

    logic accept;
    logic unused_wr_bits;

    assign accept         = wr_en & ~lock;
    assign unused_wr_bits = ^wr_data[DW-1:CW];

    always_ff @(posedge clk) begin
        if (rst) begin
            guard    <= '0;
            ctrl     <= '0;
            stop_opt <= '0;
        end else if (accept) begin
            if (wr_addr == AW'(ADDR_GUARD)) guard    <= guard_t'(wr_data[GW-1:0]);
            if (wr_addr == AW'(ADDR_CTRL))  ctrl     <= ctrl_t'(wr_data[CW-1:0]);
            if (wr_addr == AW'(ADDR_OPT))   stop_opt <= wr_data[1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            AW'(ADDR_GUARD): rd_data = DW'(guard);
            AW'(ADDR_CTRL):  rd_data = DW'(ctrl);
            AW'(ADDR_OPT):   rd_data = DW'(stop_opt);
            AW'(ADDR_STAT):  rd_data = DW'(status);
            default:         rd_data = '0;
        endcase
    end

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(lock) && !$past(rst)) |-> ($stable(guard) && $stable(ctrl) && $stable(stop_opt)));

endmodule

// File: rtl/pmc_planner.sv
module pmc_planner
    import pmc_pkg::*;
(
    input  pmode_e     mode,
    input  pmode_e     origin,
    input  logic       busy,
    input  guard_t     guard,
    input  ctrl_t      ctrl,
    input  logic [1:0] stop_opt,
    input  logic       sleep_req,
    input  logic       wake_irq,
    input  logic       ctrl_wr,
    input  logic [1:0] run_in,
    output plan_t      plan
);
    logic halted;
    logic low_stop_ok;

    assign halted      = (mode == MD_HALT1) || (mode == MD_HALT2);
    assign low_stop_ok = guard.allow_vlp &&
        ((mode == MD_RUN && ctrl.stop_sel == STOP_LOW) ||
         (mode == MD_LOWRUN && (ctrl.stop_sel == STOP_LOW || ctrl.stop_sel == STOP_PLAIN)));

    always_comb begin
        plan = '{go: 1'b0, target: MD_RUN};
        if (!busy) begin
            if (wake_irq && halted) begin
                plan = '{go: 1'b1, target: MD_RUN};
            end else if (wake_irq && mode == MD_LOWHALT) begin
                plan = '{go: 1'b1, target: origin};
            end else if (sleep_req && is_run_mode(mode)) begin
                if (mode == MD_RUN && ctrl.stop_sel == STOP_PLAIN && stop_opt == OPT_ONE)
                    plan = '{go: 1'b1, target: MD_HALT1};
                else if (mode == MD_RUN && ctrl.stop_sel == STOP_PLAIN && stop_opt == OPT_TWO)
                    plan = '{go: 1'b1, target: MD_HALT2};
                else if (low_stop_ok)
                    plan = '{go: 1'b1, target: MD_LOWHALT};
            end else if (ctrl_wr) begin
                case (mode)
                    MD_RUN: begin
                        if (run_in == RUN_HIGH && guard.allow_hs)
                            plan = '{go: 1'b1, target: MD_HIGH};
                        else if (run_in == RUN_LOW && guard.allow_vlp)
                            plan = '{go: 1'b1, target: MD_LOWRUN};
                    end
                    MD_HIGH, MD_LOWRUN: begin
                        if (run_in == RUN_NORM)
                            plan = '{go: 1'b1, target: MD_RUN};
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  plan_t  plan,
    input  logic   seq_done,
    input  guard_t guard,
    output pmode_e mode_q,
    output pmode_e origin_q,
    output pmode_e tgt_q,
    output logic   busy_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MD_RUN;
            origin_q <= MD_RUN;
            tgt_q    <= MD_RUN;
            busy_q   <= 1'b0;
        end else if (busy_q) begin
            if (seq_done) begin
                mode_q <= tgt_q;
                busy_q <= 1'b0;
            end
        end else if (plan.go) begin
            busy_q <= 1'b1;
            tgt_q  <= plan.target;
            if (plan.target == MD_LOWHALT) origin_q <= mode_q;
        end
    end

    // R10
    mode_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> ($past(rst) || $past(busy_q && seq_done)));

    // R10
    req_held_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !seq_done) |=> (busy_q && $stable(tgt_q)));

    // R4
    hs_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_HIGH && $past(mode_q) != MD_HIGH) |-> $past(guard.allow_hs));

    // R8
    vlp_guard_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_q == MD_LOWRUN || mode_q == MD_LOWHALT) && $past(mode_q) != mode_q)
            |-> $past(guard.allow_vlp));

    // R6
    no_hs_lowrun_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MD_HIGH) |-> (mode_q != MD_LOWRUN && mode_q != MD_LOWHALT));

    // R6
    no_lowrun_hs_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MD_LOWRUN) |-> (mode_q != MD_HIGH));

    // R9
    lowhalt_return_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MD_LOWHALT && mode_q != MD_LOWHALT && !$past(rst))
            |-> (mode_q == $past(origin_q)));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          sleep_req,
    input  logic          wake_irq,
    output logic          seq_req,
    output logic [2:0]    seq_target,
    input  logic          seq_done,
    output logic [7:0]    status_o
);
    guard_t     guard;
    ctrl_t      ctrl;
    logic [1:0] stop_opt;
    plan_t      plan;
    pmode_e     mode_q, origin_q, tgt_q;
    logic       busy_q;
    logic       ctrl_wr;

    assign ctrl_wr    = wr_en && !busy_q && (wr_addr == AW'(ADDR_CTRL));
    assign status_o   = status_code(mode_q);
    assign seq_req    = busy_q;
    assign seq_target = tgt_q;

    pmc_regfile #(.DW(DW), .AW(AW)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lock(busy_q), .rd_addr(rd_addr), .status(status_o),
        .guard(guard), .ctrl(ctrl), .stop_opt(stop_opt), .rd_data(rd_data)
    );

    pmc_planner plan_i (
        .mode(mode_q), .origin(origin_q), .busy(busy_q), .guard(guard), .ctrl(ctrl),
        .stop_opt(stop_opt), .sleep_req(sleep_req), .wake_irq(wake_irq),
        .ctrl_wr(ctrl_wr), .run_in(wr_data[1:0]), .plan(plan)
    );

    pmc_mode_fsm fsm_i (
        .clk(clk), .rst(rst), .plan(plan), .seq_done(seq_done), .guard(guard),
        .mode_q(mode_q), .origin_q(origin_q), .tgt_q(tgt_q), .busy_q(busy_q)
    );

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;
    localparam int PERIOD = 10;
    localparam int DW = 8;
    localparam int AW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = 2'd3;
    logic [DW-1:0] rd_data;
    logic sleep_req = 1'b0;
    logic wake_irq = 1'b0;
    logic seq_req;
    logic [2:0] seq_target;
    logic seq_done = 1'b0;
    logic [7:0] status_o;

    int vec = 0;
    int bad = 0;
    int seq_lat = 2;

    int m_mode = 0, m_busy = 0, m_tgt = 0, m_org = 0;
    int m_prot = 0, m_ctrl = 0, m_opt = 0;

    always #(PERIOD/2) clk = ~clk;

    pwr_mode_ctrl #(.DW(DW), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sleep_req(sleep_req), .wake_irq(wake_irq),
        .seq_req(seq_req), .seq_target(seq_target), .seq_done(seq_done), .status_o(status_o)
    );

    function automatic logic [7:0] code_of(int m);
        case (m)
            0: return 8'h01;
            1: return 8'h80;
            2: return 8'h04;
            3: return 8'h10;
            4: return 8'h20;
            5: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] model_read(int a);
        case (a)
            0: return 8'(m_prot);
            1: return 8'(m_ctrl);
            2: return 8'(m_opt);
            default: return code_of(m_mode);
        endcase
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    // behavioural reference: one step per clock
    always @(posedge clk) begin : ref_model
        int nt, stp, rn;
        if (rst) begin
            m_mode = 0; m_busy = 0; m_tgt = 0; m_org = 0;
            m_prot = 0; m_ctrl = 0; m_opt = 0;
        end else if (m_busy != 0) begin
            if (seq_done) begin
                m_mode = m_tgt;
                m_busy = 0;
            end
        end else begin
            nt  = -1;
            stp = (m_ctrl >> 2) & 7;
            if (wake_irq && (m_mode == 3 || m_mode == 4)) nt = 0;
            else if (wake_irq && m_mode == 5) nt = m_org;
            else if (sleep_req && m_mode <= 2) begin
                if (m_mode == 0) begin
                    if (stp == 0 && m_opt == 1) nt = 3;
                    else if (stp == 0 && m_opt == 2) nt = 4;
                    else if (stp == 2 && (m_prot & 1) != 0) nt = 5;
                end else if (m_mode == 2) begin
                    if ((stp == 0 || stp == 2) && (m_prot & 1) != 0) nt = 5;
                end
            end else if (wr_en && wr_addr == 2'd1 && m_mode <= 2) begin
                rn = int'(wr_data) & 3;
                if (m_mode == 0) begin
                    if (rn == 3 && (m_prot & 2) != 0) nt = 1;
                    else if (rn == 2 && (m_prot & 1) != 0) nt = 2;
                end else if (rn == 0) nt = 0;
            end
            if (nt >= 0) begin
                if (nt == 5) m_org = m_mode;
                m_tgt  = nt;
                m_busy = 1;
            end
            if (wr_en) begin
                case (int'(wr_addr))
                    0: m_prot = int'(wr_data) & 3;
                    1: m_ctrl = int'(wr_data) & 31;
                    2: m_opt  = int'(wr_data) & 3;
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            chk("R3 status per cycle", status_o, code_of(m_mode));
            chk("R10 seq_req per cycle", {7'd0, seq_req}, 8'(m_busy));
            if (m_busy != 0) chk("R10 seq_target per cycle", {5'd0, seq_target}, 8'(m_tgt));
            chk("R2 read port per cycle", rd_data, model_read(int'(rd_addr)));
        end
    end

    // sequencer model
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (seq_done) seq_done = 1'b0;
            else if (seq_req) begin
                cnt++;
                if (cnt >= seq_lat) begin
                    seq_done = 1'b1;
                    cnt = 0;
                end
            end else cnt = 0;
        end
    end

    initial begin
        #(PERIOD * 200000);
        vec++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    task automatic wr(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sleep_pulse();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic wake_pulse();
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
    endtask

    task automatic settle();
        repeat (seq_lat + 4) @(negedge clk);
    endtask

    task automatic rd_chk(string tag, logic [AW-1:0] a, logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
        rd_addr = 2'd3;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 reset status", status_o, 8'h01);
        chk("R1 reset seq_req", {7'd0, seq_req}, 8'h00);
        rd_chk("R1 guard cleared", 2'd0, 8'h00);
        rd_chk("R1 ctrl cleared", 2'd1, 8'h00);

        // R4 denied without guard
        wr(2'd1, 8'h03);
        chk("R4 high-speed denied seq_req", {7'd0, seq_req}, 8'h00);
        settle();
        chk("R4 high-speed denied status", status_o, 8'h01);

        // R2 register readback
        wr(2'd0, 8'hFF);
        rd_chk("R2 guard readback", 2'd0, 8'h03);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h02);
        rd_chk("R2 option readback", 2'd2, 8'h02);

        // R10 handshake and R4 enter high-speed
        wr(2'd1, 8'h03);
        chk("R10 seq_req raised", {7'd0, seq_req}, 8'h01);
        chk("R10 target high-speed", {5'd0, seq_target}, 8'h01);
        chk("R10 old status held", status_o, 8'h01);
        settle();
        chk("R4 high-speed entered", status_o, 8'h80);

        // R6 rejections in high-speed run
        wr(2'd1, 8'h02);
        settle();
        chk("R6 high-speed to low-run rejected", status_o, 8'h80);
        sleep_pulse();
        settle();
        chk("R6 sleep in high-speed rejected", status_o, 8'h80);

        // R5
        wr(2'd1, 8'h00);
        settle();
        chk("R5 high-speed back to run", status_o, 8'h01);

        // low-power run, R6 reverse, R8 and R9
        wr(2'd1, 8'h02);
        settle();
        chk("R4 low-power run entered", status_o, 8'h04);
        wr(2'd1, 8'h03);
        settle();
        chk("R6 low-run to high-speed rejected", status_o, 8'h04);
        wr(2'd1, 8'h02);
        sleep_pulse();
        settle();
        chk("R8 low-stop from low-run stop 000", status_o, 8'h40);
        wake_pulse();
        settle();
        chk("R9 low-stop wakes to low-run", status_o, 8'h04);
        wr(2'd1, 8'h0A);
        sleep_pulse();
        settle();
        chk("R8 low-stop from low-run stop 010", status_o, 8'h40);
        wake_pulse();
        settle();
        chk("R9 wake back to low-run again", status_o, 8'h04);
        wr(2'd1, 8'h08);
        settle();
        chk("R5 low-run back to run", status_o, 8'h01);
        sleep_pulse();
        settle();
        chk("R8 low-stop from run", status_o, 8'h40);
        wake_pulse();
        settle();
        chk("R9 low-stop entered from run wakes to run", status_o, 8'h01);

        // R7 stop variants
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h01);
        sleep_pulse();
        settle();
        chk("R7 stop1 entered", status_o, 8'h10);
        wake_pulse();
        settle();
        chk("R9 stop1 wakes to run", status_o, 8'h01);
        wr(2'd2, 8'h02);
        sleep_pulse();
        settle();
        chk("R7 stop2 entered", status_o, 8'h20);
        wake_pulse();
        settle();
        chk("R9 stop2 wakes to run", status_o, 8'h01);
        wr(2'd2, 8'h00);
        sleep_pulse();
        settle();
        chk("R7 option 00 rejected", status_o, 8'h01);

        // R11 writes ignored during a move
        seq_lat = 6;
        wr(2'd1, 8'h03);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h03);
        settle();
        chk("R11 move completed", status_o, 8'h80);
        rd_chk("R11 guard unchanged", 2'd0, 8'h03);
        rd_chk("R11 option unchanged", 2'd2, 8'h00);
        seq_lat = 2;
        wr(2'd1, 8'h00);
        settle();

        // R4 and R8 with low-power modes disallowed
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h02);
        settle();
        chk("R4 low-run denied", status_o, 8'h01);
        wr(2'd1, 8'h08);
        sleep_pulse();
        settle();
        chk("R8 low-stop denied", status_o, 8'h01);

        // R12 reset from low-power run
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h02);
        settle();
        chk("R12 precondition low-run", status_o, 8'h04);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 reset returns to run", status_o, 8'h01);
        rd_chk("R12 guard cleared", 2'd0, 8'h00);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule